// File: doc/BRIEF.md
# System Control Coprocessor Register Bank

This block holds the processor's control and status registers behind a move-to / move-from coprocessor port. Each access gives a register number and a secondary operation code. Four writable registers are stored: system control, page table base, data fault status and fault address. Two read-only values, a CPU identification word and a cache type word, are fixed by parameters.

Writes to the cache maintenance register number and the TLB maintenance register number are not stored. The opcode is decoded instead, and the result goes out as a one-cycle command pulse to the cache or the TLB. A line operation also drives the write data out as the line address. Any access whose register and opcode pair is not recognised raises a one-cycle illegal-access pulse. The block also gates the hardware interrupt request with the interrupt-disable bit held in the system control register.

All pins are plain control and status signals. The access port has no handshake: an access is taken on every rising edge where `acc_en` is high, and there is no back-pressure.

Top module: `scp_bank`

## Requirements
- R1: A synchronous active-high `rst` clears registers 1 to 4 to zero, and clears `cache_cmd`, `tlb_cmd` and `illegal`.
- R2: A write (`acc_en`=1, `acc_wr`=1) to register 1, 2, 3 or 4 with opcode 0 stores `acc_wdata` at the rising edge. After that edge the value reads back on `rd_data`, which is combinational from `acc_reg`/`acc_op`.
- R3: A read of register 0 returns `CPU_ID` with opcode 0 and `CACHE_TYPE` with opcode 1. A write to register 0 is unrecognised and changes nothing.
- R4: A write to register 5 pulses one `cache_cmd` bit, selected by opcode: 28→bit0 (invalidate I+D all), 20→bit1 (invalidate I all), 12→bit2 (invalidate D all), 10→bit3 (clean D all), 14→bit4 (flush D all), 13→bit5 (invalidate D line), 11→bit6 (clean D line), 15→bit7 (flush D line). Any other opcode is unrecognised.
- R5: For the line operations (bits 5 to 7), `line_addr` equals the write data in the same cycle as the pulse.
- R6: A write to register 6 with an opcode from 2 to 6 inclusive pulses `tlb_cmd`. Any other opcode is unrecognised.
- R7: A read of an unrecognised register and opcode pair returns zero. This covers register 1 to 4 with a nonzero opcode, register 0 with an opcode above 1, and registers 5 and up.
- R8: A write of an unrecognised pair leaves every stored register unchanged.
- R9: Any unrecognised access with `acc_en` high pulses `illegal` in the cycle after its edge, and only then.
- R10: Command and illegal pulses are registered. They appear after the edge that takes the access and drop after the next edge unless that edge takes another access.
- R11: `irq_take` is `irq_req` AND NOT bit `IRQ_DIS_BIT` of the system control register (register 1), combinationally.
- R12: Registers 5 and 6 hold no state. Reading them after a command write still returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_en | input | 1 | Access taken at this edge |
| acc_wr | input | 1 | 1 = move-to (write), 0 = move-from (read) |
| acc_reg | input | REG_W | Register number |
| acc_op | input | OP_W | Secondary operation code |
| acc_wdata | input | DW | Write data |
| rd_data | output | DW | Read data for `acc_reg`/`acc_op` |
| cache_cmd | output | 8 | One-hot cache maintenance pulses |
| line_addr | output | DW | Line address for line operations |
| tlb_cmd | output | 1 | Flush-all TLB pulse |
| illegal | output | 1 | Unrecognised access pulse |
| irq_req | input | 1 | Hardware interrupt request |
| irq_take | output | 1 | Interrupt request passed on |

## Verification
The bench builds the block with DW=16, OP_W=6, IRQ_DIS_BIT=3, CPU_ID=16'hA5C3 and CACHE_TYPE=16'h1234. The narrow data path makes distinct patterns quick to drive. The 6-bit opcode reaches values above the cache opcode range, which lets the bench confirm that those opcodes are rejected and not aliased. A disable bit away from bit 0 checks that the interrupt gate looks at the correct position. The bench also sweeps register 5 over the whole opcode space and register 6 over opcodes 0 to 8, so every decode boundary is exercised.

// File: rtl/scp_pkg.sv
package scp_pkg;
  localparam int NCMD      = 8;
  localparam int NSTORE    = 4;
  localparam int RG_ID     = 0;
  localparam int RG_CACHE  = 5;
  localparam int RG_TLB    = 6;
  localparam int TLB_LO    = 2;
  localparam int TLB_HI    = 6;
  localparam logic [NCMD-1:0] LINE_OPS = 8'hE0;

  // maps a cache opcode to its one-hot command bit; zero when unknown
  function automatic logic [NCMD-1:0] cache_decode(input int unsigned op);
    logic [NCMD-1:0] r;
    case (op)
      28: r = 8'h01;
      20: r = 8'h02;
      12: r = 8'h04;
      10: r = 8'h08;
      14: r = 8'h10;
      13: r = 8'h20;
      11: r = 8'h40;
      15: r = 8'h80;
      default: r = '0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/scp_decode.sv
module scp_decode
  import scp_pkg::*;
#(
  parameter int REG_W = 4,
  parameter int OP_W  = 6
) (
  input  logic             acc_en,
  input  logic             acc_wr,
  input  logic [REG_W-1:0] acc_reg,
  input  logic [OP_W-1:0]  acc_op,
  output logic [NSTORE-1:0] wr_sel,
  output logic [NSTORE-1:0] rd_sel,
  output logic             rd_id,
  output logic             rd_ct,
  output logic [NCMD-1:0]  cache_hit,
  output logic             tlb_hit,
  output logic             bad
);
  logic op_zero;
  logic is_wr;
  logic rd_ok;
  logic wr_ok;

  assign op_zero = (acc_op == '0);
  assign is_wr   = acc_en & acc_wr;

  for (genvar g = 0; g < NSTORE; g++) begin : g_sel
    assign rd_sel[g] = op_zero & (acc_reg == REG_W'(g + 1));
    assign wr_sel[g] = is_wr & rd_sel[g];
  end

  assign rd_id = (acc_reg == REG_W'(RG_ID)) & op_zero;
  assign rd_ct = (acc_reg == REG_W'(RG_ID)) & (acc_op == OP_W'(1));

  always_comb begin
    cache_hit = '0;
    if (is_wr && acc_reg == REG_W'(RG_CACHE))
      cache_hit = cache_decode(int'(acc_op));
  end

  assign tlb_hit = is_wr & (acc_reg == REG_W'(RG_TLB))
                 & (acc_op >= OP_W'(TLB_LO)) & (acc_op <= OP_W'(TLB_HI));

  assign rd_ok = (|rd_sel) | rd_id | rd_ct;
  assign wr_ok = (|wr_sel) | (|cache_hit) | tlb_hit;
  assign bad   = acc_en & (acc_wr ? ~wr_ok : ~rd_ok);
endmodule

// File: rtl/scp_store.sv
module scp_store
  import scp_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NSTORE-1:0]           wr_sel,
  input  logic [DW-1:0]               wdata,
  output logic [NSTORE-1:0][DW-1:0]   q
);
  for (genvar g = 0; g < NSTORE; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)            q[g] <= '0;
      else if (wr_sel[g]) q[g] <= wdata;
    end
  end
endmodule

// File: rtl/scp_cmd.sv
module scp_cmd
  import scp_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NCMD-1:0] cache_hit,
  input  logic            tlb_hit,
  input  logic            bad,
  input  logic [DW-1:0]   wdata,
  output logic [NCMD-1:0] cache_cmd,
  output logic            tlb_cmd,
  output logic            illegal,
  output logic [DW-1:0]   line_addr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cache_cmd <= '0;
      tlb_cmd   <= 1'b0;
      illegal   <= 1'b0;
      line_addr <= '0;
    end else begin
      cache_cmd <= cache_hit;
      tlb_cmd   <= tlb_hit;
      illegal   <= bad;
      if (|(cache_hit & LINE_OPS)) line_addr <= wdata;
    end
  end
endmodule

// File: rtl/scp_bank.sv
module scp_bank
  import scp_pkg::*;
#(
  parameter int            DW          = 32,
  parameter int            REG_W       = 4,
  parameter int            OP_W        = 6,
  parameter int            IRQ_DIS_BIT = 7,
  parameter logic [DW-1:0] CPU_ID      = 32'h4D00_0863,
  parameter logic [DW-1:0] CACHE_TYPE  = 32'h0D15_2152
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_en,
  input  logic             acc_wr,
  input  logic [REG_W-1:0] acc_reg,
  input  logic [OP_W-1:0]  acc_op,
  input  logic [DW-1:0]    acc_wdata,
  output logic [DW-1:0]    rd_data,
  output logic [7:0]       cache_cmd,
  output logic [DW-1:0]    line_addr,
  output logic             tlb_cmd,
  output logic             illegal,
  input  logic             irq_req,
  output logic             irq_take
);
  localparam int SYS_IDX = 0;

  logic [NSTORE-1:0]         wr_sel;
  logic [NSTORE-1:0]         rd_sel;
  logic                      rd_id;
  logic                      rd_ct;
  logic [NCMD-1:0]           cache_hit;
  logic                      tlb_hit;
  logic                      bad;
  logic [NSTORE-1:0][DW-1:0] bank_q;

  scp_decode #(.REG_W(REG_W), .OP_W(OP_W)) u_dec (
    .acc_en   (acc_en),
    .acc_wr   (acc_wr),
    .acc_reg  (acc_reg),
    .acc_op   (acc_op),
    .wr_sel   (wr_sel),
    .rd_sel   (rd_sel),
    .rd_id    (rd_id),
    .rd_ct    (rd_ct),
    .cache_hit(cache_hit),
    .tlb_hit  (tlb_hit),
    .bad      (bad)
  );

  scp_store #(.DW(DW)) u_store (
    .clk   (clk),
    .rst   (rst),
    .wr_sel(wr_sel),
    .wdata (acc_wdata),
    .q     (bank_q)
  );

  scp_cmd #(.DW(DW)) u_cmd (
    .clk      (clk),
    .rst      (rst),
    .cache_hit(cache_hit),
    .tlb_hit  (tlb_hit),
    .bad      (bad),
    .wdata    (acc_wdata),
    .cache_cmd(cache_cmd),
    .tlb_cmd  (tlb_cmd),
    .illegal  (illegal),
    .line_addr(line_addr)
  );

  always_comb begin
    rd_data = '0;
    if (rd_id) rd_data = CPU_ID;
    if (rd_ct) rd_data = CACHE_TYPE;
    for (int i = 0; i < NSTORE; i++)
      if (rd_sel[i]) rd_data = bank_q[i];
  end

  assign irq_take = irq_req & ~bank_q[SYS_IDX][IRQ_DIS_BIT];
endmodule

// File: rtl/scp_bank_chk.sv
module scp_bank_chk #(
  parameter int            DW         = 32,
  parameter int            REG_W      = 4,
  parameter int            OP_W       = 6,
  parameter logic [DW-1:0] CPU_ID     = '0,
  parameter logic [DW-1:0] CACHE_TYPE = '0
) (
  input logic             clk,
  input logic             rst,
  input logic             acc_en,
  input logic             acc_wr,
  input logic [REG_W-1:0] acc_reg,
  input logic [OP_W-1:0]  acc_op,
  input logic [DW-1:0]    rd_data,
  input logic [7:0]       cache_cmd,
  input logic             tlb_cmd,
  input logic             illegal,
  input logic             irq_req,
  input logic             irq_take
);
  // R4
  cache_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cache_cmd, tlb_cmd}));

  // R10
  cache_src_chk: assert property (@(posedge clk) disable iff (rst)
    (|cache_cmd) |-> $past(acc_en && acc_wr && acc_reg == REG_W'(5)));

  // R6
  tlb_src_chk: assert property (@(posedge clk) disable iff (rst)
    tlb_cmd |-> $past(acc_en && acc_wr && acc_reg == REG_W'(6)
                      && acc_op >= OP_W'(2) && acc_op <= OP_W'(6)));

  // R9
  illegal_src_chk: assert property (@(posedge clk) disable iff (rst)
    illegal |-> $past(acc_en));

  // R7
  high_reg_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_reg >= REG_W'(5)) |-> (rd_data == '0));

  // R3
  id_read_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_reg == '0 && acc_op == '0) |-> (rd_data == CPU_ID));

  // R3
  ct_read_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_reg == '0 && acc_op == OP_W'(1)) |-> (rd_data == CACHE_TYPE));

  // R11
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    irq_take |-> irq_req);
endmodule

bind scp_bank scp_bank_chk #(
  .DW(DW), .REG_W(REG_W), .OP_W(OP_W), .CPU_ID(CPU_ID), .CACHE_TYPE(CACHE_TYPE)
) u_chk (
  .clk(clk), .rst(rst), .acc_en(acc_en), .acc_wr(acc_wr), .acc_reg(acc_reg),
  .acc_op(acc_op), .rd_data(rd_data), .cache_cmd(cache_cmd), .tlb_cmd(tlb_cmd),
  .illegal(illegal), .irq_req(irq_req), .irq_take(irq_take)
);

// File: tb/test_scp_bank.sv
module test_scp_bank;
  localparam int            DW  = 16;
  localparam int            RW  = 4;
  localparam int            OW  = 6;
  localparam int            DIS = 3;
  localparam logic [DW-1:0] ID  = 16'hA5C3;
  localparam logic [DW-1:0] CT  = 16'h1234;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          acc_en = 1'b0;
  logic          acc_wr = 1'b0;
  logic [RW-1:0] acc_reg = '0;
  logic [OW-1:0] acc_op = '0;
  logic [DW-1:0] acc_wdata = '0;
  logic [DW-1:0] rd_data;
  logic [7:0]    cache_cmd;
  logic [DW-1:0] line_addr;
  logic          tlb_cmd;
  logic          illegal;
  logic          irq_req = 1'b0;
  logic          irq_take;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  scp_bank #(.DW(DW), .REG_W(RW), .OP_W(OW), .IRQ_DIS_BIT(DIS),
             .CPU_ID(ID), .CACHE_TYPE(CT)) i_scp_bank (
    .clk(clk), .rst(rst), .acc_en(acc_en), .acc_wr(acc_wr), .acc_reg(acc_reg),
    .acc_op(acc_op), .acc_wdata(acc_wdata), .rd_data(rd_data),
    .cache_cmd(cache_cmd), .line_addr(line_addr), .tlb_cmd(tlb_cmd),
    .illegal(illegal), .irq_req(irq_req), .irq_take(irq_take)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got=%h exp=%h", req, what, got, exp);
    end
  endtask

  // one access taken at the next edge; returns just after that edge
  task automatic access(input logic wr, input int r, input int op,
                        input logic [DW-1:0] d);
    @(negedge clk);
    acc_en = 1'b1; acc_wr = wr; acc_reg = RW'(r); acc_op = OW'(op); acc_wdata = d;
    @(posedge clk); #1;
    acc_en = 1'b0; acc_wr = 1'b0;
  endtask

  // combinational read with no access taken
  task automatic peek(input int r, input int op, output logic [DW-1:0] v);
    @(negedge clk);
    acc_en = 1'b0; acc_reg = RW'(r); acc_op = OW'(op);
    #1 v = rd_data;
  endtask

  function automatic logic [7:0] exp_cache(input int op);
    case (op)
      28: return 8'h01; 20: return 8'h02; 12: return 8'h04; 10: return 8'h08;
      14: return 8'h10; 13: return 8'h20; 11: return 8'h40; 15: return 8'h80;
      default: return 8'h00;
    endcase
  endfunction

  task automatic t_reset();
    logic [DW-1:0] v;
    chk("R1", "cache_cmd", 32'(cache_cmd), 0);
    chk("R1", "tlb_cmd", 32'(tlb_cmd), 0);
    chk("R1", "illegal", 32'(illegal), 0);
    for (int r = 1; r <= 4; r++) begin
      peek(r, 0, v);
      chk("R1", "reg after reset", 32'(v), 0);
    end
  endtask

  task automatic t_rw();
    logic [DW-1:0] v;
    for (int r = 1; r <= 4; r++) begin
      access(1'b1, r, 0, DW'(16'h1100 * r + 16'h0055));
      chk("R2", "no illegal on valid write", 32'(illegal), 0);
    end
    for (int r = 1; r <= 4; r++) begin
      peek(r, 0, v);
      chk("R2", "readback", 32'(v), 32'(16'h1100 * r + 16'h0055));
    end
  endtask

  task automatic t_id();
    logic [DW-1:0] v;
    peek(0, 0, v); chk("R3", "cpu id", 32'(v), 32'(ID));
    peek(0, 1, v); chk("R3", "cache type", 32'(v), 32'(CT));
    access(1'b1, 0, 0, 16'hFFFF);
    chk("R3", "write reg0 illegal", 32'(illegal), 1);
    peek(0, 0, v); chk("R3", "id unchanged", 32'(v), 32'(ID));
    peek(0, 2, v); chk("R7", "reg0 op2 zero", 32'(v), 0);
  endtask

  task automatic t_cache();
    for (int op = 0; op < 64; op++) begin
      logic [7:0] e;
      e = exp_cache(op);
      access(1'b1, 5, op, DW'(16'h8000 + op));
      chk("R4", $sformatf("cache op %0d", op), 32'(cache_cmd), 32'(e));
      chk("R9", $sformatf("cache op %0d illegal", op), 32'(illegal), 32'(e == 0));
      if ((e & 8'hE0) != 0)
        chk("R5", "line_addr", 32'(line_addr), 32'(16'h8000 + op));
      @(posedge clk); #1;
      chk("R10", "pulse dropped", 32'({cache_cmd, illegal}), 0);
    end
  endtask

  task automatic t_tlb();
    for (int op = 0; op <= 8; op++) begin
      logic e;
      e = (op >= 2 && op <= 6);
      access(1'b1, 6, op, 16'h0);
      chk("R6", $sformatf("tlb op %0d", op), 32'(tlb_cmd), 32'(e));
      chk("R9", $sformatf("tlb op %0d illegal", op), 32'(illegal), 32'(!e));
    end
    @(posedge clk); #1;
    chk("R10", "tlb dropped", 32'(tlb_cmd), 0);
  endtask

  task automatic t_badrd();
    logic [DW-1:0] v;
    peek(1, 1, v); chk("R7", "reg1 op1", 32'(v), 0);
    peek(4, 7, v); chk("R7", "reg4 op7", 32'(v), 0);
    peek(9, 0, v); chk("R7", "reg9", 32'(v), 0);
    access(1'b0, 2, 3, 16'h0);
    chk("R9", "bad read illegal", 32'(illegal), 1);
    access(1'b0, 2, 0, 16'h0);
    chk("R9", "good read not illegal", 32'(illegal), 0);
  endtask

  task automatic t_badwr();
    logic [DW-1:0] v;
    access(1'b1, 2, 3, 16'hDEAD);
    chk("R9", "bad write illegal", 32'(illegal), 1);
    access(1'b1, 7, 0, 16'hBEEF);
    for (int r = 1; r <= 4; r++) begin
      peek(r, 0, v);
      chk("R8", "reg unchanged", 32'(v), 32'(16'h1100 * r + 16'h0055));
    end
  endtask

  task automatic t_nostore();
    logic [DW-1:0] v;
    access(1'b1, 5, 13, 16'h7777);
    access(1'b1, 6, 4, 16'h6666);
    for (int op = 0; op < 32; op += 4) begin
      peek(5, op, v); chk("R12", "reg5 read", 32'(v), 0);
    end
    peek(6, 4, v); chk("R12", "reg6 read", 32'(v), 0);
  endtask

  task automatic t_irq();
    access(1'b1, 1, 0, 16'h0000);
    irq_req = 1'b1; #1;
    chk("R11", "irq enabled", 32'(irq_take), 1);
    access(1'b1, 1, 0, 16'h0008);
    chk("R11", "irq disabled", 32'(irq_take), 0);
    access(1'b1, 1, 0, 16'hFFF7);
    chk("R11", "other bits no effect", 32'(irq_take), 1);
    irq_req = 1'b0; #1;
    chk("R11", "no request", 32'(irq_take), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_rw();
    t_id();
    t_cache();
    t_tlb();
    t_badrd();
    t_badwr();
    t_nostore();
    t_irq();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(8 * 100000);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: got=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule